// File: doc/BRIEF.md
# Supply Monitor Interrupt Controller

This block sits between an analog low-supply comparator and a processor. It holds one 32-bit control/status word on a simple synchronous register port. Software uses that word to switch the monitor on and to pick one of two trip levels, which the block drives straight out to the comparator. The comparator's digital result arrives asynchronously. A two-stage synchronizer brings it into the clock domain, and the synchronized value can be read back live. Whenever the monitor is enabled and the supply is low, the block sets a sticky interrupt flag and presents it to the processor as an interrupt request.

The flag is a write-one-to-clear bit with an extra condition. A clear is honoured only in a cycle where the synchronized comparator reads high. While the supply stays low the flag keeps setting itself, so the interrupt is held until the supply has recovered. There is no delay before a clear is allowed. The first cycle in which the comparator reads high already accepts one.

The flag is tracked by a three-state machine:

- FLG_IDLE: the flag is clear.
- FLG_LOW: the flag is set and the supply is low.
- FLG_HELD: the flag is set and the supply has recovered.

The transitions are:

- IDLE->LOW: the supply is seen low.
- LOW->HELD: the supply returns high.
- LOW->IDLE: the supply returns high and a clear is written in the same cycle.
- HELD->LOW: the supply drops again.
- HELD->IDLE: a clear is written.

Top module: `supmon_ctrl`

## Requirements
- R1: After reset the register reads 0x00000008 (bit 3 = 1 because the monitor is off), the interrupt request output is 0 and the trip-select output is 0.
- R2: Bit 2 is a read/write trip-level select (0 = lower level, 1 = upper level), and its stored value drives the trip-select output from the cycle after the write.
- R3: Bit 1 is a read/write enable. While it is 0, bit 3 reads 1 and the flag is never set, whatever the comparator input does.
- R4: While enabled, bit 3 shows the comparator input after two clock edges of synchronization. The flag (bit 0) becomes 1 on the next edge after bit 3 reads 0.
- R5: Writing 1 to bit 0 clears the flag only when bit 3 reads 1 in that cycle. If bit 3 reads 0, the set condition wins and the flag stays 1.
- R6: The first cycle in which bit 3 reads 1 already accepts a clear, with no added delay.
- R7: Writing 0 to bit 0 leaves the flag unchanged.
- R8: The interrupt request output is the flag gated by the enable bit, so a pending flag gives no request while the monitor is disabled.
- R9: Bits 31:3 ignore writes, and bits 31:4 always read as zero.
- R10: A write to any address other than the register address (0) changes nothing, and a read of any other address returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Word address of the access |
| bus_wr_en | input | 1 | Write strobe, sampled on the rising edge |
| bus_rd_en | input | 1 | Read enable, read data is combinational |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when not reading the register |
| cmp_async_i | input | 1 | Asynchronous comparator result, 1 = supply above the trip level |
| trip_sel_o | output | 1 | Trip-level select to the comparator |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
A wrong flag state machine shows at the ports within one clock edge after the triggering event. Bit 0 of the read word and the interrupt output would either miss a set one edge after bit 3 falls, or drop when a clear is written while bit 3 still reads low. A synchronizer of the wrong depth moves the fall of bit 3 by a whole cycle, and the cycle-exact vector table catches that. A bad enable gate shows as the interrupt output staying high after disable, or as a flag appearing while bit 3 is forced to 1.

// File: rtl/supmon_pkg.sv
package supmon_pkg;

    localparam int unsigned CSR_W      = 32;
    localparam int unsigned BIT_FLAG   = 0;
    localparam int unsigned BIT_EN     = 1;
    localparam int unsigned BIT_TRIP   = 2;
    localparam int unsigned BIT_CMP    = 3;
    localparam int unsigned USED_BITS  = 4;

    typedef enum logic [1:0] {
        FLG_IDLE = 2'd0,
        FLG_LOW  = 2'd1,
        FLG_HELD = 2'd2
    } flag_state_t;

endpackage

// File: rtl/supmon_sync.sv
module supmon_sync #(
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    localparam int unsigned LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    generate
        genvar gi;
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= RESET_VAL;
                    else        chain_q[0] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[gi] <= RESET_VAL;
                    else        chain_q[gi] <= chain_q[gi-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[LAST];

endmodule

// File: rtl/supmon_regs.sv
module supmon_regs
    import supmon_pkg::*;
#(
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned CSR_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    input  logic [CSR_W-1:0]  bus_wdata,
    output logic [CSR_W-1:0]  bus_rdata,
    input  logic              cmp_eff,
    input  logic              flag,
    output logic              en_q,
    output logic              trip_q,
    output logic              clr_req
);

    localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(CSR_ADDR);

    logic hit;
    logic wr_hit;

    assign hit    = (bus_addr == HIT_ADDR);
    assign wr_hit = bus_wr_en && hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            trip_q <= 1'b0;
        end else if (wr_hit) begin
            en_q   <= bus_wdata[BIT_EN];
            trip_q <= bus_wdata[BIT_TRIP];
        end
    end

    assign clr_req = wr_hit && bus_wdata[BIT_FLAG];

    always_comb begin
        bus_rdata = '0;
        if (bus_rd_en && hit) begin
            bus_rdata[BIT_FLAG] = flag;
            bus_rdata[BIT_EN]   = en_q;
            bus_rdata[BIT_TRIP] = trip_q;
            bus_rdata[BIT_CMP]  = cmp_eff;
        end
    end

endmodule

// File: rtl/supmon_flag_fsm.sv
module supmon_flag_fsm
    import supmon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmp_eff,
    input  logic clr_req,
    output logic flag
);

    flag_state_t state_q;
    flag_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_IDLE: begin
                if (!cmp_eff) state_d = FLG_LOW;
            end
            FLG_LOW: begin
                if (cmp_eff && clr_req) state_d = FLG_IDLE;
                else if (cmp_eff)       state_d = FLG_HELD;
            end
            FLG_HELD: begin
                if (!cmp_eff)     state_d = FLG_LOW;
                else if (clr_req) state_d = FLG_IDLE;
            end
            default: state_d = FLG_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            FLG_LOW,
            FLG_HELD: flag = 1'b1;
            default:  flag = 1'b0;
        endcase
    end

endmodule

// File: rtl/supmon_ctrl.sv
module supmon_ctrl
    import supmon_pkg::*;
#(
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned CSR_ADDR    = 0,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              cmp_async_i,
    output logic              trip_sel_o,
    output logic              irq_o
);

    logic cmp_sync;
    logic cmp_eff;
    logic en_q;
    logic trip_q;
    logic clr_req;
    logic flag;

    supmon_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (cmp_async_i),
        .sync_o  (cmp_sync)
    );

    assign cmp_eff = en_q ? cmp_sync : 1'b1;

    supmon_regs #(
        .ADDR_W   (ADDR_W),
        .CSR_ADDR (CSR_ADDR)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr_en (bus_wr_en),
        .bus_rd_en (bus_rd_en),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cmp_eff   (cmp_eff),
        .flag      (flag),
        .en_q      (en_q),
        .trip_q    (trip_q),
        .clr_req   (clr_req)
    );

    supmon_flag_fsm fsm_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmp_eff (cmp_eff),
        .clr_req (clr_req),
        .flag    (flag)
    );

    assign trip_sel_o = trip_q;
    assign irq_o      = flag & en_q;

endmodule

// File: rtl/supmon_ctrl_chk.sv
module supmon_ctrl_chk #(
    parameter int unsigned ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr_en,
    input logic [31:0]       bus_wdata,
    input logic              cmp_sync,
    input logic              cmp_eff,
    input logic              en_q,
    input logic              clr_req,
    input logic              flag,
    input logic              trip_sel_o,
    input logic              irq_o
);

    AST_SET_WHEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !cmp_sync) |=> flag); // R4

    AST_NO_SET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !flag) |=> !flag); // R3

    AST_CLEAR_BLOCKED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !cmp_eff) |=> flag); // R5

    AST_CLEAR_WHEN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && cmp_eff && clr_req) |=> !flag); // R6

    AST_ZERO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr_req) |=> flag); // R7

    AST_TRIP_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == '0) |=> (trip_sel_o == $past(bus_wdata[2]))); // R2

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (flag && en_q)); // R8

endmodule

bind supmon_ctrl supmon_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr_en  (bus_wr_en),
    .bus_wdata  (bus_wdata),
    .cmp_sync   (cmp_sync),
    .cmp_eff    (cmp_eff),
    .en_q       (en_q),
    .clr_req    (clr_req),
    .flag       (flag),
    .trip_sel_o (trip_sel_o),
    .irq_o      (irq_o)
);

// File: tb/supmon_ctrl_tb.sv
`timescale 1ns/1ps
module supmon_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr_en = 1'b0;
    logic        bus_rd_en = 1'b1;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cmp_async_i = 1'b1;
    logic        trip_sel_o;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    supmon_ctrl dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wr_en   (bus_wr_en),
        .bus_rd_en   (bus_rd_en),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .cmp_async_i (cmp_async_i),
        .trip_sel_o  (trip_sel_o),
        .irq_o       (irq_o)
    );

    typedef struct packed {
        logic        cmp;
        logic        wr;
        logic [31:0] wd;
        logic [31:0] rd;
        logic        irq;
        logic        trip;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 24;

    // One entry per clock: inputs applied, one rising edge, outputs checked.
    localparam vec_t VECS [0:NVEC-1] = '{
        '{1'b1, 1'b1, 32'h6,        32'hE, 1'b0, 1'b1, 4'd3},  // R3 enable, R2 upper level
        '{1'b0, 1'b0, 32'h0,        32'hE, 1'b0, 1'b1, 4'd4},  // R4 first stage only
        '{1'b0, 1'b0, 32'h0,        32'h6, 1'b0, 1'b1, 4'd4},  // R4 bit 3 falls
        '{1'b0, 1'b1, 32'h7,        32'h7, 1'b1, 1'b1, 4'd5},  // R5 set wins over clear
        '{1'b1, 1'b1, 32'h7,        32'h7, 1'b1, 1'b1, 4'd5},  // R5 still low after sync
        '{1'b1, 1'b0, 32'h0,        32'hF, 1'b1, 1'b1, 4'd4},  // R4 recovery seen
        '{1'b1, 1'b1, 32'h6,        32'hF, 1'b1, 1'b1, 4'd7},  // R7 zero write
        '{1'b1, 1'b1, 32'h7,        32'hE, 1'b0, 1'b1, 4'd5},  // R5 clear accepted
        '{1'b1, 1'b1, 32'hFFFFFFF6, 32'hE, 1'b0, 1'b1, 4'd9},  // R9 upper bits ignored
        '{1'b1, 1'b1, 32'h2,        32'hA, 1'b0, 1'b0, 4'd2},  // R2 lower level
        '{1'b0, 1'b0, 32'h0,        32'hA, 1'b0, 1'b0, 4'd4},
        '{1'b0, 1'b0, 32'h0,        32'h2, 1'b0, 1'b0, 4'd4},
        '{1'b0, 1'b0, 32'h0,        32'h3, 1'b1, 1'b0, 4'd4},  // R4 flag set
        '{1'b1, 1'b1, 32'h1,        32'h9, 1'b0, 1'b0, 4'd8},  // R8 disable gates request
        '{1'b1, 1'b0, 32'h0,        32'h9, 1'b0, 1'b0, 4'd8},
        '{1'b1, 1'b1, 32'h1,        32'h8, 1'b0, 1'b0, 4'd5},  // R5 clear while disabled
        '{1'b0, 1'b0, 32'h0,        32'h8, 1'b0, 1'b0, 4'd3},  // R3 no set while off
        '{1'b0, 1'b0, 32'h0,        32'h8, 1'b0, 1'b0, 4'd3},
        '{1'b0, 1'b0, 32'h0,        32'h8, 1'b0, 1'b0, 4'd3},
        '{1'b0, 1'b1, 32'h2,        32'h2, 1'b0, 1'b0, 4'd3},  // R3 enable with low supply
        '{1'b0, 1'b1, 32'h3,        32'h3, 1'b1, 1'b0, 4'd5},  // R5 set wins
        '{1'b1, 1'b1, 32'h3,        32'h3, 1'b1, 1'b0, 4'd5},
        '{1'b1, 1'b0, 32'h0,        32'hB, 1'b1, 1'b0, 4'd6},  // R6 bit 3 just rose
        '{1'b1, 1'b1, 32'h3,        32'hA, 1'b0, 1'b0, 4'd6}   // R6 first-high clear
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        apply_reset();
        // R1 reset state
        check("R1 rdata", bus_rdata, 32'h8);
        check("R1 irq", {31'b0, irq_o}, 32'h0);
        check("R1 trip", {31'b0, trip_sel_o}, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            cmp_async_i = VECS[i].cmp;
            bus_wr_en   = VECS[i].wr;
            bus_wdata   = VECS[i].wd;
            @(negedge clk);
            bus_wr_en = 1'b0;
            check($sformatf("R%0d vec%0d rdata", VECS[i].req, i), bus_rdata, VECS[i].rd);
            check($sformatf("R%0d vec%0d irq", VECS[i].req, i), {31'b0, irq_o}, {31'b0, VECS[i].irq});
            check($sformatf("R%0d vec%0d trip", VECS[i].req, i), {31'b0, trip_sel_o}, {31'b0, VECS[i].trip});
        end

        // R10 write to another address changes nothing; read there gives zero
        bus_addr  = 4'd1;
        bus_wr_en = 1'b1;
        bus_wdata = 32'h7;
        @(negedge clk);
        bus_wr_en = 1'b0;
        check("R10 miss read", bus_rdata, 32'h0);
        bus_addr = 4'd0;
        #0.1;
        check("R10 unchanged", bus_rdata, 32'hA);
        check("R10 trip", {31'b0, trip_sel_o}, 32'h0);

        // R1 reset in mid-run with flag pending
        cmp_async_i = 1'b0;
        repeat (4) @(negedge clk);
        check("R4 flag set before reset", bus_rdata, 32'h3);
        cmp_async_i = 1'b1;
        bus_wr_en = 1'b1;
        bus_wdata = 32'h6;
        @(negedge clk);
        bus_wr_en = 1'b0;
        apply_reset();
        check("R1 after reset", bus_rdata, 32'h8);
        check("R1 irq after reset", {31'b0, irq_o}, 32'h0);
        check("R1 trip after reset", {31'b0, trip_sel_o}, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule